// File: doc/BRIEF.md
# Packet-Oriented Integer ALU

This block is the execute stage of a 32-bit RISC integer pipe. Each cycle it may accept one instruction word together with the two register operand values read for it. The first operand is the value named by the source field; the second is the value named by the target field. From the primary opcode and the function code it selects an operation and computes a 32-bit result. That result is captured in a one-deep output register, which carries a valid flag and an illegal-operation flag.

Besides the usual add, subtract, logic, compare and shift operations, the unit has four operations aimed at packet header handling:

- a dual-halfword add in which no carry crosses the halfword boundary;
- a rotate followed by a mask applied from both ends;
- a shift-left or shift-right whose mask width comes from a register;
- an AND with an immediate whose upper half is forced to ones.

Register file access, memory access and exception handling belong to the rest of the core. No arithmetic overflow is ever reported.

The instruction word is split into fixed fields, which both the decoder and the datapath use:

| Bits | Field |
|------|-------|
| 31:26 | opcode |
| 25:21 | source register number |
| 20:16 | target register number |
| 10:6 | shift amount |
| 5:0 | function code |
| 15:0 | immediate |
| 4:0 | left-mask width |

Top module: `pkt_alu_unit`

## Requirements
- R1: While `rstN` is low, and right after it rises, `outValid`, `outIllegal` and `outResult` are all zero.
- R2: An instruction presented with `inValid` high at a rising clock edge shows its result on `outResult` and `outIllegal` after that same edge. `outValid` equals `inValid` from the previous edge. While `inValid` is low, `outResult` and `outIllegal` keep their values.
- R3: With opcode 0, function code 32 or 33 gives a + b and 34 or 35 gives a − b, both modulo 2^32. Function code 36 gives a AND b, 37 gives OR, 38 gives XOR and 39 gives NOR.
- R4: Opcodes 8 and 9 give a plus the sign-extended immediate. Opcodes 12, 13 and 14 give AND, OR and XOR of a with the zero-extended immediate. Opcode 15 gives the immediate in bits 31:16 with zeros below. Opcode 44 gives a AND {16'hFFFF, immediate}.
- R5: Set-less-than results are exactly 1 or 0:
  - function code 42: a < b, signed;
  - function code 43: a < b, unsigned;
  - opcode 10: a < sign-extended immediate, signed;
  - opcode 11: a < sign-extended immediate, unsigned.
- R6: With opcode 0, function codes 0, 2 and 3 shift b left logical, right logical and right arithmetic by the shift-amount field. Function codes 4, 6 and 7 do the same shifts by a[4:0] only; a[31:5] has no effect.
- R7: Function code 41 gives {a[31:16]+b[31:16], a[15:0]+b[15:0]}. Each half is truncated to 16 bits, so no carry passes from the low half to the high half.
- R8: Opcode 39 rotates b right by the shift-amount field. The rotated value is then ANDed with (all-ones >> left-mask width, instruction bits 4:0). It is then ANDed with (all-ones << source register number, instruction bits 25:21).
- R9: Function code 1 gives (b << shift amount) AND (all-ones >> a[4:0]). Function code 5 gives (b >> shift amount, logical) AND (all-ones << a[4:0]).
- R10: Any other opcode, or any other function code under opcode 0, gives a zero result with `outIllegal` set. Every legal operation clears `outIllegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| opA | input | 32 | Value of the source register |
| opB | input | 32 | Value of the target register |
| outValid | output | 1 | Registered result is new this cycle |
| outResult | output | 32 | Registered result |
| outIllegal | output | 1 | Registered flag for an unrecognised operation |

## Verification
The assertions rely on `instr`, `opA` and `opB` being settled, known values whenever `inValid` is high at a clock edge. They also rely on reset being held for at least one edge before the first instruction. The stimulus drives every input only on the falling clock edge, and it holds reset low for several cycles before starting. Random instruction words are built from the legal opcode and function code lists, with random register, shift, mask and immediate fields and random operands. Directed words cover carry at the halfword seam, zero and full-width masks, shift amounts with high bits set in a, and several illegal codes.

// File: rtl/pkt_alu_pkg.sv
package pkt_alu_pkg;

  typedef enum logic [4:0] {
    OP_NONE,  OP_ADD,  OP_SUB,  OP_AND,  OP_OR,   OP_XOR,
    OP_NOR,   OP_SLT,  OP_SLTU, OP_SLL,  OP_SRL,  OP_SRA,
    OP_SLMV,  OP_SRMV, OP_ADO16, OP_RAM, OP_LUI
  } aluOp_e;

  typedef enum logic [1:0] {
    B_REG,   // target register value
    B_SEXT,  // sign-extended immediate
    B_ZEXT,  // zero-extended immediate
    B_ONES   // immediate under an all-ones upper half
  } bSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    aluOp_e op;
    bSrc_e  bSrc;
    logic   shVar;    // shift amount from a[4:0] instead of the field
    logic   illegal;
  } aluCtrl_t;

  // primary opcodes
  localparam logic [5:0] OPC_SPECIAL = 6'd0;
  localparam logic [5:0] OPC_ADDI    = 6'd8;
  localparam logic [5:0] OPC_ADDIU   = 6'd9;
  localparam logic [5:0] OPC_SLTI    = 6'd10;
  localparam logic [5:0] OPC_SLTIU   = 6'd11;
  localparam logic [5:0] OPC_ANDI    = 6'd12;
  localparam logic [5:0] OPC_ORI     = 6'd13;
  localparam logic [5:0] OPC_XORI    = 6'd14;
  localparam logic [5:0] OPC_LUI     = 6'd15;
  localparam logic [5:0] OPC_ROTMSK  = 6'd39;
  localparam logic [5:0] OPC_ANDONES = 6'd44;

endpackage

// File: rtl/pkt_alu_ctrl.sv
module pkt_alu_ctrl
  import pkt_alu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{op: OP_NONE, bSrc: B_REG, shVar: 1'b0, illegal: 1'b0};
    unique case (opcode)
      OPC_SPECIAL: begin
        unique case (funct)
          6'd0:  ctrl.op = OP_SLL;
          6'd1:  ctrl.op = OP_SLMV;
          6'd2:  ctrl.op = OP_SRL;
          6'd3:  ctrl.op = OP_SRA;
          6'd4:  begin ctrl.op = OP_SLL; ctrl.shVar = 1'b1; end
          6'd5:  ctrl.op = OP_SRMV;
          6'd6:  begin ctrl.op = OP_SRL; ctrl.shVar = 1'b1; end
          6'd7:  begin ctrl.op = OP_SRA; ctrl.shVar = 1'b1; end
          6'd32, 6'd33: ctrl.op = OP_ADD;
          6'd34, 6'd35: ctrl.op = OP_SUB;
          6'd36: ctrl.op = OP_AND;
          6'd37: ctrl.op = OP_OR;
          6'd38: ctrl.op = OP_XOR;
          6'd39: ctrl.op = OP_NOR;
          6'd41: ctrl.op = OP_ADO16;
          6'd42: ctrl.op = OP_SLT;
          6'd43: ctrl.op = OP_SLTU;
          default: ctrl.illegal = 1'b1;
        endcase
      end
      OPC_ADDI, OPC_ADDIU: begin ctrl.op = OP_ADD;  ctrl.bSrc = B_SEXT; end
      OPC_SLTI:            begin ctrl.op = OP_SLT;  ctrl.bSrc = B_SEXT; end
      OPC_SLTIU:           begin ctrl.op = OP_SLTU; ctrl.bSrc = B_SEXT; end
      OPC_ANDI:            begin ctrl.op = OP_AND;  ctrl.bSrc = B_ZEXT; end
      OPC_ORI:             begin ctrl.op = OP_OR;   ctrl.bSrc = B_ZEXT; end
      OPC_XORI:            begin ctrl.op = OP_XOR;  ctrl.bSrc = B_ZEXT; end
      OPC_ANDONES:         begin ctrl.op = OP_AND;  ctrl.bSrc = B_ONES; end
      OPC_LUI:             ctrl.op = OP_LUI;
      OPC_ROTMSK:          ctrl.op = OP_RAM;
      default:             ctrl.illegal = 1'b1;
    endcase
  end

  // R10: an illegal decode must never carry an operation
  always_comb begin
    if (ctrl.illegal)
      assert_illegal_no_op_R10: assert (ctrl.op == OP_NONE);
  end

endmodule

// File: rtl/pkt_alu_dp.sv
module pkt_alu_dp
  import pkt_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic [$clog2(DATA_W)-1:0] shamtF,
  input  logic [$clog2(DATA_W)-1:0] rsF,
  input  logic [$clog2(DATA_W)-1:0] maskL,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult,
  output logic              outIllegal
);

  localparam int SH_W   = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = DATA_W - IMM_W;
  localparam logic [DATA_W-1:0] ONES = '1;

  logic [SH_W-1:0]     shAmt;
  logic [DATA_W-1:0]   bOp;
  logic [2*DATA_W-1:0] rotPair;
  logic [DATA_W-1:0]   rotVal;
  logic [DATA_W-1:0]   aluRes;
  logic [HALF_W-1:0]   sumLo, sumHi;

  assign shAmt   = ctrl.shVar ? opA[SH_W-1:0] : shamtF;
  assign rotPair = {opB, opB} >> shAmt;
  assign rotVal  = rotPair[DATA_W-1:0];
  assign sumLo   = opA[HALF_W-1:0] + opB[HALF_W-1:0];
  assign sumHi   = opA[DATA_W-1:HALF_W] + opB[DATA_W-1:HALF_W];

  always_comb begin
    unique case (ctrl.bSrc)
      B_SEXT:  bOp = {{EXT_W{imm[IMM_W-1]}}, imm};
      B_ZEXT:  bOp = {{EXT_W{1'b0}}, imm};
      B_ONES:  bOp = {{EXT_W{1'b1}}, imm};
      default: bOp = opB;
    endcase
  end

  always_comb begin
    unique case (ctrl.op)
      OP_ADD:   aluRes = opA + bOp;
      OP_SUB:   aluRes = opA - bOp;
      OP_AND:   aluRes = opA & bOp;
      OP_OR:    aluRes = opA | bOp;
      OP_XOR:   aluRes = opA ^ bOp;
      OP_NOR:   aluRes = ~(opA | bOp);
      OP_SLT:   aluRes = {{(DATA_W-1){1'b0}}, ($signed(opA) < $signed(bOp))};
      OP_SLTU:  aluRes = {{(DATA_W-1){1'b0}}, (opA < bOp)};
      OP_SLL:   aluRes = opB << shAmt;
      OP_SRL:   aluRes = opB >> shAmt;
      OP_SRA:   aluRes = $unsigned($signed(opB) >>> shAmt);
      OP_SLMV:  aluRes = (opB << shAmt) & (ONES >> opA[SH_W-1:0]);
      OP_SRMV:  aluRes = (opB >> shAmt) & (ONES << opA[SH_W-1:0]);
      OP_ADO16: aluRes = {sumHi, sumLo};
      OP_RAM:   aluRes = rotVal & (ONES >> maskL) & (ONES << rsF);
      OP_LUI:   aluRes = {imm, {EXT_W{1'b0}}};
      default:  aluRes = '0;
    endcase
  end

  // R5: compare results are a single bit
  always_comb begin
    if (rstN && (ctrl.op == OP_SLT || ctrl.op == OP_SLTU))
      assert_slt_one_bit_R5: assert (aluRes[DATA_W-1:1] == '0);
  end

  // output stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outResult  <= '0;
      outIllegal <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outResult  <= aluRes;
        outIllegal <= ctrl.illegal;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outResult) && $stable(outIllegal)));

  assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    outIllegal |-> (outResult == '0));

endmodule

// File: rtl/pkt_alu_unit.sv
module pkt_alu_unit
  import pkt_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult,
  output logic              outIllegal
);

  aluCtrl_t ctrl;

  pkt_alu_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  pkt_alu_dp #(.DATA_W(DATA_W), .IMM_W(16)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .ctrl       (ctrl),
    .opA        (opA),
    .opB        (opB),
    .imm        (instr[15:0]),
    .shamtF     (instr[10:6]),
    .rsF        (instr[25:21]),
    .maskL      (instr[4:0]),
    .outValid   (outValid),
    .outResult  (outResult),
    .outIllegal (outIllegal)
  );

endmodule

// File: tb/sim_pkt_alu_unit.sv
`timescale 1ns/1ps
module sim_pkt_alu_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0, opA = '0, opB = '0;
  logic        outValid, outIllegal;
  logic [31:0] outResult;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] prevRes = '0;
  logic        prevIll = 1'b0;

  always #10 clk = ~clk;

  pkt_alu_unit u0 (.clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
                   .opA(opA), .opB(opB), .outValid(outValid),
                   .outResult(outResult), .outIllegal(outIllegal));

  function automatic string reqOf(input logic [31:0] w);
    logic [5:0] o = w[31:26], f = w[5:0];
    if (o == 0) begin
      if (f inside {32,33,34,35,36,37,38,39}) return "R3";
      if (f inside {0,2,3,4,6,7}) return "R6";
      if (f == 41) return "R7";
      if (f inside {1,5}) return "R9";
      if (f inside {42,43}) return "R5";
      return "R10";
    end
    if (o inside {8,9,12,13,14,15,44}) return "R4";
    if (o inside {10,11}) return "R5";
    if (o == 39) return "R8";
    return "R10";
  endfunction

  function automatic logic [31:0] model(input logic [31:0] w, a, b, output logic ill);
    logic [5:0] o = w[31:26], f = w[5:0];
    logic [4:0] sa = w[10:6];
    logic [31:0] se = {{16{w[15]}}, w[15:0]};
    logic [31:0] ze = {16'h0, w[15:0]};
    logic [31:0] r, ones = 32'hFFFF_FFFF;
    ill = 1'b0;
    r = 32'h0;
    case (o)
      0: case (f)
        0: r = b << sa;
        1: r = (b << sa) & (ones >> a[4:0]);
        2: r = b >> sa;
        3: r = $unsigned($signed(b) >>> sa);
        4: r = b << a[4:0];
        5: r = (b >> sa) & (ones << a[4:0]);
        6: r = b >> a[4:0];
        7: r = $unsigned($signed(b) >>> a[4:0]);
        32, 33: r = a + b;
        34, 35: r = a - b;
        36: r = a & b;
        37: r = a | b;
        38: r = a ^ b;
        39: r = ~(a | b);
        41: begin
          r[15:0]  = a[15:0] + b[15:0];
          r[31:16] = a[31:16] + b[31:16];
        end
        42: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        43: r = (a < b) ? 32'd1 : 32'd0;
        default: ill = 1'b1;
      endcase
      8, 9: r = a + se;
      10: r = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
      11: r = (a < se) ? 32'd1 : 32'd0;
      12: r = a & ze;
      13: r = a | ze;
      14: r = a ^ ze;
      15: r = {w[15:0], 16'h0};
      44: r = a & {16'hFFFF, w[15:0]};
      39: begin
        r = (sa == 0) ? b : ((b >> sa) | (b << (6'd32 - {1'b0, sa})));
        r = r & (ones >> w[4:0]) & (ones << w[25:21]);
      end
      default: ill = 1'b1;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, a, b, input bit v);
    logic ill;
    logic [31:0] er;
    string req;
    @(negedge clk);
    instr = w; opA = a; opB = b; inValid = v;
    er = model(w, a, b, ill);
    req = v ? reqOf(w) : "R2";
    @(negedge clk);
    inValid = 1'b0;
    check("R2", "outValid", {31'b0, outValid}, {31'b0, v});
    if (v) begin
      check(req, "result", outResult, er);
      check(req, "illegal", {31'b0, outIllegal}, {31'b0, ill});
      prevRes = er; prevIll = ill;
    end else begin
      check("R2", "held result", outResult, prevRes);
      check("R2", "held illegal", {31'b0, outIllegal}, {31'b0, prevIll});
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] o, input logic [4:0] rs, rt,
                                     input logic [15:0] low);
    return {o, rs, rt, low};
  endfunction

  localparam int NF = 19;
  localparam int NO = 10;
  logic [5:0] functs [NF] = '{0,1,2,3,4,5,6,7,32,33,34,35,36,37,38,39,41,42,43};
  logic [5:0] opcs   [NO] = '{8,9,10,11,12,13,14,15,39,44};

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset valid", {31'b0, outValid}, 32'd0);
    check("R1", "reset result", outResult, 32'd0);
    check("R1", "reset illegal", {31'b0, outIllegal}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "post-reset valid", {31'b0, outValid}, 32'd0);

    // directed corner cases
    issue(mk(0, 1, 2, {5'd3, 5'd0, 6'd41}), 32'h0001_FFFF, 32'h0001_0001, 1);   // R7 seam carry dropped
    issue(mk(0, 1, 2, {5'd3, 5'd0, 6'd41}), 32'hFFFF_8000, 32'h0001_8000, 1);   // R7 both halves wrap
    issue(mk(0, 1, 2, {11'd0, 6'd4}), 32'hFFFF_FFE3, 32'h0000_0001, 1);         // R6 only a[4:0]
    issue(mk(0, 1, 2, {11'd0, 6'd7}), 32'h0000_0124, 32'h8000_0000, 1);         // R6 arith by 4
    issue(mk(0, 1, 2, {5'd0, 5'd31, 6'd3}), 32'h0, 32'h8000_0000, 1);           // R6 sra 31
    issue(mk(39, 5'd4, 2, {5'd0, 5'd8, 1'b0, 5'd8}), 32'h0, 32'h1234_5678, 1);  // R8
    issue(mk(39, 5'd0, 2, {5'd0, 5'd0, 1'b0, 5'd0}), 32'h0, 32'hCAFE_F00D, 1);  // R8 no mask no rotate
    issue(mk(0, 1, 2, {5'd0, 5'd4, 6'd1}), 32'h0000_0008, 32'hFFFF_FFFF, 1);    // R9 slmv
    issue(mk(0, 1, 2, {5'd0, 5'd4, 6'd5}), 32'h0000_0010, 32'hFFFF_FFFF, 1);    // R9 srmv
    issue(mk(44, 1, 2, 16'h00F0), 32'hDEAD_BEEF, 32'h0, 1);                     // R4 and-ones
    issue(mk(15, 0, 2, 16'hABCD), 32'h1, 32'h2, 1);                             // R4 upper imm
    issue(mk(11, 1, 2, 16'hFFFF), 32'hFFFF_FFFE, 32'h0, 1);                     // R5 unsigned vs sext
    issue(mk(10, 1, 2, 16'hFFFF), 32'hFFFF_FFFE, 32'h0, 1);                     // R5 signed
    issue(mk(0, 1, 2, {11'd0, 6'd42}), 32'h8000_0000, 32'h1, 1);                // R5 slt
    issue(mk(0, 1, 2, {11'd0, 6'd43}), 32'h8000_0000, 32'h1, 1);                // R5 sltu
    issue(mk(0, 1, 2, {11'd0, 6'd32}), 32'h7FFF_FFFF, 32'h1, 1);                // R3 no overflow flag
    issue(mk(2, 1, 2, 16'h1234), 32'h5, 32'h6, 1);                              // R10 bad opcode
    issue(mk(0, 1, 2, {11'd0, 6'd8}), 32'h5, 32'h6, 1);                         // R10 bad function
    issue(mk(0, 1, 2, {11'd0, 6'd40}), 32'h5, 32'h6, 1);                        // R10
    issue(mk(0, 1, 2, {11'd0, 6'd36}), 32'hF0F0_F0F0, 32'hFF00_FF00, 1);        // R10 legal clears flag
    issue(mk(0, 1, 2, {11'd0, 6'd38}), 32'h1111, 32'h2222, 0);                  // R2 idle hold
    issue(mk(7, 1, 2, 16'h0), 32'h1, 32'h1, 0);                                 // R2 idle illegal ignored

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom % 2 == 0) begin
        w[31:26] = 6'd0;
        w[5:0] = functs[$urandom % NF];
      end else begin
        w[31:26] = opcs[$urandom % NO];
      end
      if ($urandom % 50 == 0) w[31:26] = 6'd16 + 6'($urandom % 8);  // R10 random illegal
      issue(w, $urandom, $urandom, ($urandom % 8) != 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule